// File: doc/BRIEF.md
# UART Channel Mode and FIFO Path Control

This block sits between a host register port, a serial receive engine, a serial transmit engine and two byte FIFOs. It holds a small control register and a channel-mode register. Every cycle it decides where each incoming byte goes: into the receive FIFO, into the transmit FIFO, into both, or nowhere. It also reports the cases where a byte was lost because its FIFO was full.

Four channel modes are supported: normal, automatic echo, local loopback and remote loopback. The receive path and the transmit path each have an enable bit and a disable bit, and the disable bit wins. Each FIFO can be cleared through a control bit that clears itself. A break request produces a one-cycle pulse. The block also tells the receive engine how many bytes it may still deliver, based on the FIFOs that the current mode writes into.

Top module: `uart_chmode_ctrl`

## Requirements
- R1: Register select 1 is the mode register. Its bits 9:8 hold the channel mode: 0 normal, 1 automatic echo, 2 local loopback, 3 remote loopback. A read with select 1 returns the mode in bits 9:8 and zeros elsewhere. The register resets to normal.
- R2: A byte from the receive engine (`rx_valid` high for one cycle) is handled according to the mode. It enters the receive FIFO in normal and echo modes. It enters the transmit FIFO in echo and remote-loopback modes. It is dropped in local loopback.
- R3: A host write with select 2 (the data register) puts bits 7:0 into the transmit FIFO in normal mode and into the receive FIFO in local-loopback mode. In echo and remote-loopback modes the write is dropped.
- R4: The receive path is active only while control bit 2 is 1 and control bit 3 is 0. The transmit path is active only while control bit 4 is 1 and control bit 5 is 0. A push towards an inactive path is dropped, changes no count and raises no event.
- R5: A write with select 0 (the control register) that has bit 0 set empties the receive FIFO at that clock edge. Bit 1 does the same for the transmit FIFO. The clear wins over a push in the same cycle. Bits 0 and 1 always read back as 0.
- R6: In the cycle after a control write with bit 7 set and bit 8 clear, `break_start` is high for exactly one cycle. Any other write gives no pulse.
- R7: A push into a full receive FIFO stores nothing and pulses `rx_ovr_evt` in the following cycle. Fullness is judged on the count before any pop in the same cycle.
- R8: A push into a full transmit FIFO stores nothing and pulses `tx_ovf_evt` in the following cycle.
- R9: A read with select 2 returns the oldest receive byte and removes it. If the receive FIFO is empty, or the receive path is inactive, the read returns 0 and the count does not change.
- R10: After reset the control register reads 0x128, the mode is normal, both counts are 0 and no event is high. A read with select 3, or no read at all, returns 0.
- R11: `rx_room` is the free space of the receive FIFO in normal mode, and of the transmit FIFO in remote loopback. In echo mode it is the smaller of the two. In local loopback it is the full depth.
- R12: `tx_valid` is high while the transmit FIFO holds data, and `tx_byte` is its oldest byte. The byte is removed on `tx_valid && tx_ready`. Both FIFOs keep first-in first-out order. `rx_count` and `tx_count` give their occupancy in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 mode, 2 data |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Read data, valid in the same cycle as `reg_rd` |
| rx_valid | input | 1 | Byte from the receive engine |
| rx_byte | input | DW | Received byte |
| rx_room | output | CNT_W | Bytes the receive engine may still deliver |
| tx_valid | output | 1 | Transmit FIFO has a byte |
| tx_byte | output | DW | Oldest transmit byte |
| tx_ready | input | 1 | Transmit engine takes `tx_byte` |
| break_start | output | 1 | One-cycle break request |
| rx_ovr_evt | output | 1 | Receive overrun pulse |
| tx_ovf_evt | output | 1 | Transmit overflow pulse |
| rx_count | output | CNT_W | Receive FIFO occupancy |
| tx_count | output | CNT_W | Transmit FIFO occupancy |

## Verification
The routing is tried in all four modes with the same stimulus: single received bytes and host data writes, each followed by draining through the transmit handshake and by data reads. This shows which FIFO each mode writes and confirms that local loopback ignores the serial input. Both FIFOs are filled one byte past their depth, which shows that fullness is judged on the count before a same-cycle pop and that the overrun and overflow pulses stay separate. Control writes combine the enable and disable bits and the clear bits with a same-cycle receive byte. This shows that a disable bit dominates and that a clear dominates a push. Break writes with and without bit 8 show when the pulse is produced.

// File: rtl/uart_chmode_pkg.sv
package uart_chmode_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam int REG_W    = 10;
  localparam int CTRL_W   = 9;
  localparam int MODE_LSB = 8;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;

  localparam int CB_RXCLR   = 0;
  localparam int CB_TXCLR   = 1;
  localparam int CB_RXEN    = 2;
  localparam int CB_RXOFF   = 3;
  localparam int CB_TXEN    = 4;
  localparam int CB_TXOFF   = 5;
  localparam int CB_BRKGO   = 7;
  localparam int CB_BRKHALT = 8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // A path is open when its enable is set and its disable is clear.
  function automatic logic path_open(input logic en, input logic off);
    return en & ~off;
  endfunction

  // Serial bytes go to the receive FIFO in these modes.
  function automatic logic serial_to_rx(input chan_mode_e m);
    return (m == CM_NORMAL) || (m == CM_ECHO);
  endfunction

  // Serial bytes go to the transmit FIFO in these modes.
  function automatic logic serial_to_tx(input chan_mode_e m);
    return (m == CM_ECHO) || (m == CM_REMOTE);
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R7
  push_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_chmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output chan_mode_e        mode_q,
  output logic              rx_on,
  output logic              tx_on,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              brk_q
);

  logic ctrl_wr, mode_wr, brk_req;

  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign mode_wr = wr && (sel == SEL_MODE);
  assign rx_clr  = ctrl_wr & wdata[CB_RXCLR];
  assign tx_clr  = ctrl_wr & wdata[CB_TXCLR];
  assign brk_req = ctrl_wr & wdata[CB_BRKGO] & ~wdata[CB_BRKHALT];

  assign rx_on = path_open(ctrl_q[CB_RXEN], ctrl_q[CB_RXOFF]);
  assign tx_on = path_open(ctrl_q[CB_TXEN], ctrl_q[CB_TXOFF]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      mode_q <= CM_NORMAL;
      brk_q  <= 1'b0;
    end else begin
      brk_q <= brk_req;
      if (ctrl_wr) ctrl_q <= {wdata[CTRL_W-1:2], 2'b00};
      if (mode_wr) mode_q <= chan_mode_e'(wdata[MODE_LSB +: 2]);
    end
  end

endmodule

// File: rtl/chmode_router.sv
module chmode_router
  import uart_chmode_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  chan_mode_e       mode,
  input  logic             rx_on,
  input  logic             tx_on,
  input  logic             ser_valid,
  input  logic [DW-1:0]    ser_byte,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_byte,
  input  logic             rx_full,
  input  logic             tx_full,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  output logic             rx_push,
  output logic [DW-1:0]    rx_din,
  output logic             tx_push,
  output logic [DW-1:0]    tx_din,
  output logic             rx_ovr,
  output logic             tx_ovf,
  output logic [CNT_W-1:0] room
);

  logic rx_req_ser, rx_req_host, rx_req;
  logic tx_req_ser, tx_req_host, tx_req;

  function automatic logic [CNT_W-1:0] free_of(input logic [CNT_W-1:0] c);
    return CNT_W'(DEPTH) - c;
  endfunction

  function automatic logic [CNT_W-1:0] smaller(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  assign rx_req_ser  = ser_valid & serial_to_rx(mode) & rx_on;
  assign rx_req_host = host_wr & (mode == CM_LOCAL) & rx_on;
  assign rx_req      = rx_req_ser | rx_req_host;
  assign rx_din      = rx_req_host ? host_byte : ser_byte;
  assign rx_push     = rx_req & ~rx_full;
  assign rx_ovr      = rx_req & rx_full;

  assign tx_req_ser  = ser_valid & serial_to_tx(mode) & tx_on;
  assign tx_req_host = host_wr & (mode == CM_NORMAL) & tx_on;
  assign tx_req      = tx_req_ser | tx_req_host;
  assign tx_din      = tx_req_host ? host_byte : ser_byte;
  assign tx_push     = tx_req & ~tx_full;
  assign tx_ovf      = tx_req & tx_full;

  always_comb begin
    case (mode)
      CM_NORMAL: room = free_of(rx_cnt);
      CM_ECHO:   room = smaller(free_of(rx_cnt), free_of(tx_cnt));
      CM_LOCAL:  room = CNT_W'(DEPTH);
      default:   room = free_of(tx_cnt);
    endcase
  end

endmodule

// File: rtl/uart_chmode_ctrl.sv
module uart_chmode_ctrl
  import uart_chmode_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  output logic [CNT_W-1:0] rx_room,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_byte,
  input  logic             tx_ready,
  output logic             break_start,
  output logic             rx_ovr_evt,
  output logic             tx_ovf_evt,
  output logic [CNT_W-1:0] rx_count,
  output logic [CNT_W-1:0] tx_count
);

  logic [CTRL_W-1:0] ctrl_q;
  chan_mode_e        mode_q;
  logic              rx_on, tx_on, rx_clr, tx_clr;
  logic              rx_push, tx_push, rx_ovr_w, tx_ovf_w;
  logic [DW-1:0]     rx_din, tx_din, rx_head;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic              data_wr, data_rd, rx_pop, tx_pop;

  assign data_wr = reg_wr && (reg_sel == SEL_DATA);
  assign data_rd = reg_rd && (reg_sel == SEL_DATA);
  assign rx_pop  = data_rd & rx_on & ~rx_empty;
  assign tx_valid = ~tx_empty;
  assign tx_pop   = tx_valid & tx_ready;

  uart_ctrl_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q),
    .mode_q (mode_q),
    .rx_on  (rx_on),
    .tx_on  (tx_on),
    .rx_clr (rx_clr),
    .tx_clr (tx_clr),
    .brk_q  (break_start)
  );

  chmode_router #(.DEPTH(DEPTH), .DW(DW)) u_route (
    .mode      (mode_q),
    .rx_on     (rx_on),
    .tx_on     (tx_on),
    .ser_valid (rx_valid),
    .ser_byte  (rx_byte),
    .host_wr   (data_wr),
    .host_byte (reg_wdata[DW-1:0]),
    .rx_full   (rx_full),
    .tx_full   (tx_full),
    .rx_cnt    (rx_count),
    .tx_cnt    (tx_count),
    .rx_push   (rx_push),
    .rx_din    (rx_din),
    .tx_push   (tx_push),
    .tx_din    (tx_din),
    .rx_ovr    (rx_ovr_w),
    .tx_ovf    (tx_ovf_w),
    .room      (rx_room)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .push  (rx_push),
    .din   (rx_din),
    .pop   (rx_pop),
    .head  (rx_head),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_clr),
    .push  (tx_push),
    .din   (tx_din),
    .pop   (tx_pop),
    .head  (tx_byte),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovr_evt <= 1'b0;
      tx_ovf_evt <= 1'b0;
    end else begin
      rx_ovr_evt <= rx_ovr_w;
      tx_ovf_evt <= tx_ovf_w;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_sel)
        SEL_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
        SEL_MODE: reg_rdata[MODE_LSB +: 2] = mode_q;
        SEL_DATA: if (rx_on && !rx_empty) reg_rdata[DW-1:0] = rx_head;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R6
  brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CTRL && reg_wdata[CB_BRKGO] && !reg_wdata[CB_BRKHALT])
      |=> break_start);

  // R6
  brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == SEL_CTRL && reg_wdata[CB_BRKGO] && !reg_wdata[CB_BRKHALT])
      |=> !break_start);

  // R7
  rx_ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_evt |-> ($past(rx_count) == CNT_W'(DEPTH)));

  // R8
  tx_ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_evt |-> ($past(tx_count) == CNT_W'(DEPTH)));

  // R11
  room_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_LOCAL) |-> (rx_room == CNT_W'(DEPTH)));

  // R5
  clr_bits_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_CTRL) |-> (reg_rdata[1:0] == 2'b00));

  // R4
  rx_closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !rx_clr) |=> (rx_count == $past(rx_count)));

endmodule

// File: tb/uart_chmode_ctrl_tb.sv
module uart_chmode_ctrl_tb;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [6:0] rx_room, rx_count, tx_count;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_byte;
  logic       break_start, rx_ovr_evt, tx_ovf_evt;

  always #5 clk = ~clk;

  uart_chmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_room(rx_room),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .break_start(break_start), .rx_ovr_evt(rx_ovr_evt),
    .tx_ovf_evt(tx_ovf_evt), .rx_count(rx_count), .tx_count(tx_count)
  );

  int n_tests = 0, n_fail = 0;
  byte unsigned rxq[$], txq[$];
  int    m_ctrl = 'h128, m_mode = 0;
  bit    e_ovr, e_ovf, e_brk;
  string req_cur = "R10";

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
               req, act, act, exp, exp, $time);
    end
  endtask

  function automatic bit rx_open();
    return m_ctrl[2] && !m_ctrl[3];
  endfunction

  function automatic bit tx_open();
    return m_ctrl[4] && !m_ctrl[5];
  endfunction

  function automatic int exp_rdata();
    if (!reg_rd) return 0;
    case (reg_sel)
      2'd0: return m_ctrl;
      2'd1: return m_mode * 256;
      2'd2: return (rx_open() && rxq.size() > 0) ? int'(rxq[0]) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_room();
    int rf = DEPTH - rxq.size();
    int tf = DEPTH - txq.size();
    case (m_mode)
      0: return rf;
      1: return (rf < tf) ? rf : tf;
      2: return DEPTH;
      default: return tf;
    endcase
  endfunction

  // Behavioural next state, evaluated on the inputs seen at the clock edge.
  task automatic model_step();
    bit rq = 0, tq = 0;
    byte unsigned rb = 0, tb = 0;
    int rsz = rxq.size(), tsz = txq.size();
    e_ovr = 0; e_ovf = 0; e_brk = 0;
    if (rx_valid && (m_mode == 0 || m_mode == 1) && rx_open()) begin rq = 1; rb = rx_byte; end
    if (reg_wr && reg_sel == 2 && m_mode == 2 && rx_open()) begin rq = 1; rb = reg_wdata[7:0]; end
    if (rx_valid && (m_mode == 1 || m_mode == 3) && tx_open()) begin tq = 1; tb = rx_byte; end
    if (reg_wr && reg_sel == 2 && m_mode == 0 && tx_open()) begin tq = 1; tb = reg_wdata[7:0]; end
    if (reg_rd && reg_sel == 2 && rx_open() && rsz > 0) void'(rxq.pop_front());
    if (tx_ready && tsz > 0) void'(txq.pop_front());
    if (rq) begin if (rsz == DEPTH) e_ovr = 1; else rxq.push_back(rb); end
    if (tq) begin if (tsz == DEPTH) e_ovf = 1; else txq.push_back(tb); end
    if (reg_wr && reg_sel == 0) begin
      if (reg_wdata[0]) rxq.delete();
      if (reg_wdata[1]) txq.delete();
      m_ctrl = int'(reg_wdata[8:0]) & 'h1FC;
      e_brk  = reg_wdata[7] && !reg_wdata[8];
    end
    if (reg_wr && reg_sel == 1) m_mode = int'(reg_wdata[9:8]);
  endtask

  task automatic cyc();
    string rtag;
    #1;
    rtag = (reg_sel == 2) ? "R9" : (reg_sel == 1) ? "R1" : req_cur;
    chk(rtag, int'(reg_rdata), exp_rdata());
    chk("R11", int'(rx_room), exp_room());
    chk("R12", int'(tx_valid), int'(txq.size() > 0));
    if (txq.size() > 0) chk("R12", int'(tx_byte), int'(txq[0]));
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(req_cur, int'(rx_count), rxq.size());
    chk(req_cur, int'(tx_count), txq.size());
    chk("R7", int'(rx_ovr_evt), int'(e_ovr));
    chk("R8", int'(tx_ovf_evt), int'(e_ovf));
    chk("R6", int'(break_start), int'(e_brk));
  endtask

  task automatic wr(int sel, int d);
    reg_wr = 1; reg_sel = 2'(sel); reg_wdata = 10'(d);
    cyc();
    reg_wr = 0; reg_sel = 0; reg_wdata = 0;
  endtask

  task automatic rd(int sel);
    reg_rd = 1; reg_sel = 2'(sel);
    cyc();
    reg_rd = 0; reg_sel = 0;
  endtask

  task automatic rxb(int b);
    rx_valid = 1; rx_byte = 8'(b);
    cyc();
    rx_valid = 0; rx_byte = 0;
  endtask

  task automatic rd_rx(int b);
    reg_rd = 1; reg_sel = 2; rx_valid = 1; rx_byte = 8'(b);
    cyc();
    reg_rd = 0; reg_sel = 0; rx_valid = 0; rx_byte = 0;
  endtask

  task automatic wr_rx(int sel, int d, int b);
    rx_valid = 1; rx_byte = 8'(b);
    wr(sel, d);
    rx_valid = 0; rx_byte = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    req_cur = "R10";
    chk("R10", int'(rx_count), 0);
    chk("R10", int'(break_start), 0);
    rd(0); rd(1); rd(3); idle(1);

    // R4: reset value keeps both paths closed
    req_cur = "R4";
    rxb('h11); wr(2, 'h12);
    wr(0, 'h1C); rxb('h22);        // rx enable with rx disable
    wr(0, 'h34); wr(2, 'h33);      // tx enable with tx disable
    wr(0, 'h04); wr(2, 'h34);      // rx open, tx closed
    rd(0);

    // R1: mode field readback
    req_cur = "R1";
    wr(1, 'h200); rd(1); wr(1, 'h300); rd(1); wr(1, 'h100); rd(1); wr(1, 0); rd(1);

    // R2 / R3: normal mode
    req_cur = "R2";
    wr(0, 'h14);
    rxb('hA1); rxb('hA2);
    req_cur = "R3";
    wr(2, 'hB1); wr(2, 'hB2);
    tx_ready = 1; idle(3); tx_ready = 0;
    rd(2); rd(2); rd(2);

    // R2 / R3: echo mode
    req_cur = "R2";
    wr(1, 'h100);
    rxb('hC1); rxb('hC2);
    req_cur = "R3";
    wr(2, 'hDD);
    tx_ready = 1; idle(1); tx_ready = 0;
    rd(2); rd(2);
    tx_ready = 1; idle(2); tx_ready = 0;

    // remote loopback
    req_cur = "R2";
    wr(1, 'h300);
    rxb('hE1); rxb('hE2);
    req_cur = "R3";
    wr(2, 'hEE);
    tx_ready = 1; idle(3); tx_ready = 0;

    // local loopback
    wr(1, 'h200);
    wr(2, 'hF1); wr(2, 'hF2);
    req_cur = "R2";
    rxb('h99);
    rd(2); rd(2); rd(2);

    // R7: receive overrun in normal mode
    req_cur = "R7";
    wr(1, 0);
    for (int i = 0; i < DEPTH + 1; i++) rxb(i + 1);
    rd_rx('h77);                   // full before the pop: dropped
    rxb('h78);                     // room after the pop: stored
    for (int i = 0; i < 4; i++) rd(2);

    // R11: echo room limited by the receive FIFO
    req_cur = "R11";
    wr(1, 'h100);
    rxb('h55);
    wr(1, 0);

    // R8: transmit overflow from host writes
    req_cur = "R8";
    for (int i = 0; i < DEPTH + 2; i++) wr(2, 'h40 + i);

    // R12: drain with a toggling ready
    req_cur = "R12";
    for (int i = 0; i < 8; i++) begin tx_ready = i[0]; cyc(); end
    tx_ready = 0;

    // R9: read with the receive path closed
    req_cur = "R9";
    rxb('h61); rxb('h62);
    wr(0, 'h1C); rd(2); rd(2);
    wr(0, 'h14); rd(2);

    // R5: FIFO clears, and clear wins over a same-cycle byte
    req_cur = "R5";
    wr_rx(0, 'h15, 'h63);
    rd(0);
    rxb('h64);
    wr_rx(0, 'h16, 'h65);
    wr(0, 'h17);
    rd(0);

    // R6: break request
    req_cur = "R6";
    wr(0, 'h94); idle(1);
    wr(0, 'h194); idle(1);
    wr(0, 'h14);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule